// File: doc/BRIEF.md
# Sleep Mode Sequencer

This block sequences a small microcontroller core into and out of low-power sleep. Two things must coincide before the core goes to sleep. The sleep-enable bit must be set, and a one-cycle pulse must mark the core executing its sleep instruction. At that moment a three-bit mode field is captured. It decides which clock domains stay enabled and which wake sources may end the sleep. The domains are CPU, flash, I/O, ADC, asynchronous timer and main oscillator.

A qualified wake source starts the exit. The sequencer first waits the start-up delay of the captured mode, then holds the core halted for a fixed four more cycles, and then raises a one-cycle resume pulse. The core uses that pulse to dispatch the interrupt and continue after its sleep instruction. The sequencer never clears register or memory state on a normal wake. A reset request that arrives while the core is asleep or waking takes a separate exit. It ends with a one-cycle reset-vector pulse instead of the resume pulse.

The sequencer also says when a brown-out detector disable request may take effect. This is allowed only in the deep modes and only while the core is asleep.

Top module: `sleep_sequencer`

## Requirements
- R1: Sleep is entered at a clock edge where `slp_exec` and `slp_en` are both 1. A `slp_exec` pulse with `slp_en` at 0 leaves the core running, with `asleep` 0 and all domains enabled.
- R2: Mode codes are 000 Idle, 001 ADC-quiet, 010 Power-down, 011 Power-save, 110 Standby and 111 Extended Standby. The reserved codes 100 and 101 behave exactly as Idle.
- R3: While asleep, `dom_en` (bit 5 CPU, 4 flash, 3 I/O, 2 ADC, 1 async timer, 0 oscillator) takes one value per mode: Idle 001111, ADC-quiet 000111, Power-down 000000, Power-save 000010, Standby 000001, Extended Standby 000011. While running, `dom_en` is 111111.
- R4: Every interrupt source wakes the core from Idle. ADC-quiet is woken by the external level lines, pin change, two-wire address match, watchdog, timer-2, ADC and memory-ready. The other four modes are woken by level lines, pin change, address match and watchdog, plus timer-2 where R6 permits. `misc_irq` wakes the core only from Idle.
- R5: Outside Idle, `ext_edge` is ignored and the core stays asleep. `ext_lvl` still wakes the core in every mode.
- R6: In Power-save and Extended Standby, `tmr2_irq` wakes the core only when `tmr2_async` is 1. In Power-down and Standby it never wakes the core.
- R7: Count the clock edge that samples the wake as edge 1. `resume` is 1 right after edge S+5, where S is 0 for Idle and ADC-quiet, 16 for Power-down and Power-save, and 6 for both Standby modes.
- R8: `core_halt` is 1 from sleep entry until the resume cycle. During the start-up wait `dom_en` is the mode value with the oscillator bit set. During the four halt cycles `dom_en` is 111111.
- R9: `resume` lasts exactly one cycle, with `core_halt` 0 and `rst_vec` 0. The core is then running again.
- R10: A `rst_req` seen at an edge while `core_halt` is 1 gives a one-cycle `rst_vec` right after that edge, with `dom_en` 111111 and no `resume`. It takes priority over a wake. While the core is running, `rst_req` has no effect.
- R11: `bod_off` is 1 only while asleep with `bod_dis_req` 1 in Power-down, Power-save, Standby or Extended Standby.
- R12: A `slp_exec` pulse while the core is asleep or waking does not change the captured mode or the domain enables.
- R13: After reset the core is running: `dom_en` 111111, with `core_halt`, `asleep`, `resume`, `rst_vec` and `bod_off` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slp_en | input | 1 | Sleep-enable bit |
| slp_mode | input | 3 | Mode select |
| slp_exec | input | 1 | One-cycle pulse marking execution of the sleep instruction |
| rst_req | input | 1 | Reset request from any system source |
| ext_lvl | input | 2 | Level-sensed external interrupt requests |
| ext_edge | input | 2 | Edge-detected external interrupt requests |
| pin_chg | input | 1 | Pin-change interrupt |
| twi_match | input | 1 | Two-wire address-match interrupt |
| wdt_irq | input | 1 | Watchdog interrupt |
| tmr2_irq | input | 1 | Timer-2 interrupt |
| tmr2_async | input | 1 | Timer-2 runs from its asynchronous clock |
| adc_irq | input | 1 | ADC conversion-complete interrupt |
| nvm_rdy | input | 1 | Memory-ready interrupt |
| misc_irq | input | 1 | Any other enabled peripheral interrupt |
| bod_dis_req | input | 1 | Request to switch off the brown-out detector during sleep |
| dom_en | output | 6 | Clock-domain enables, bit order as in R3 |
| core_halt | output | 1 | Core is held |
| asleep | output | 1 | Sleeping, waiting for a wake source |
| resume | output | 1 | One-cycle resume/dispatch pulse |
| rst_vec | output | 1 | One-cycle pulse sending the core to the reset vector |
| bod_off | output | 1 | Brown-out detector may be switched off |

## Verification
The bench builds the sequencer with its default parameters: 16 start-up cycles for Power-down and Power-save, 6 for the Standby modes, none for Idle and ADC-quiet, and a four-cycle halt. With these values, all three distinct exit lengths (5, 11 and 21 edges) are measured exactly against their expected counts. The 16-cycle wait also leaves enough time to inject a reset request in the middle of a start-up. Both reserved codes are entered, and each wake source is tried in modes where it must work and in modes where it must be ignored.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

  typedef enum logic [2:0] {
    M_IDLE  = 3'b000,
    M_ADCQ  = 3'b001,
    M_PDOWN = 3'b010,
    M_PSAVE = 3'b011,
    M_STBY  = 3'b110,
    M_XSTBY = 3'b111
  } mode_e;

  typedef enum logic [2:0] {
    ST_RUN, ST_SLEEP, ST_START, ST_HALT, ST_RESUME, ST_RSTV
  } seq_state_e;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic io;
    logic adc;
    logic atmr;
    logic osc;
  } dom_t;

  localparam int NDOM = 6;

  // Reserved codes fold onto Idle.
  function automatic mode_e fold_mode(input logic [2:0] code);
    if (code == 3'b100 || code == 3'b101) return M_IDLE;
    return mode_e'(code);
  endfunction

endpackage

// File: rtl/sleep_mode_map.sv
module sleep_mode_map
  import sleep_pkg::*;
#(
  parameter int T_IDLE  = 0,
  parameter int T_ADCQ  = 0,
  parameter int T_PDOWN = 16,
  parameter int T_PSAVE = 16,
  parameter int T_STBY  = 6,
  parameter int T_XSTBY = 6,
  parameter int CW      = 5
) (
  input  mode_e         mode,
  output dom_t          sleep_dom,
  output logic [CW-1:0] start_len,
  output logic          bod_ok
);

  always_comb begin
    sleep_dom = '0;
    start_len = '0;
    bod_ok    = 1'b0;
    unique case (mode)
      M_IDLE: begin
        sleep_dom = '{cpu:1'b0, flash:1'b0, io:1'b1, adc:1'b1, atmr:1'b1, osc:1'b1};
        start_len = CW'(T_IDLE);
      end
      M_ADCQ: begin
        sleep_dom = '{cpu:1'b0, flash:1'b0, io:1'b0, adc:1'b1, atmr:1'b1, osc:1'b1};
        start_len = CW'(T_ADCQ);
      end
      M_PDOWN: begin
        start_len = CW'(T_PDOWN);
        bod_ok    = 1'b1;
      end
      M_PSAVE: begin
        sleep_dom.atmr = 1'b1;
        start_len      = CW'(T_PSAVE);
        bod_ok         = 1'b1;
      end
      M_STBY: begin
        sleep_dom.osc = 1'b1;
        start_len     = CW'(T_STBY);
        bod_ok        = 1'b1;
      end
      M_XSTBY: begin
        sleep_dom.osc  = 1'b1;
        sleep_dom.atmr = 1'b1;
        start_len      = CW'(T_XSTBY);
        bod_ok         = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sleep_wake_qual.sv
module sleep_wake_qual
  import sleep_pkg::*;
#(
  parameter int N_EXT = 2
) (
  input  mode_e            mode,
  input  logic [N_EXT-1:0] ext_lvl,
  input  logic [N_EXT-1:0] ext_edge,
  input  logic             pin_chg,
  input  logic             twi_match,
  input  logic             wdt_irq,
  input  logic             tmr2_irq,
  input  logic             tmr2_async,
  input  logic             adc_irq,
  input  logic             nvm_rdy,
  input  logic             misc_irq,
  output logic             wake
);

  logic [N_EXT-1:0] lvl_ok;
  logic [N_EXT-1:0] edge_ok;
  logic             edge_allowed;

  assign edge_allowed = (mode == M_IDLE);

  // Per-line qualification of the external request lines.
  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    assign lvl_ok[g]  = ext_lvl[g];
    assign edge_ok[g] = ext_edge[g] & edge_allowed;
  end

  logic base_src;
  assign base_src = (|lvl_ok) | pin_chg | twi_match | wdt_irq;

  always_comb begin
    wake = 1'b0;
    unique case (mode)
      M_IDLE:  wake = base_src | (|edge_ok) | tmr2_irq | adc_irq | nvm_rdy | misc_irq;
      M_ADCQ:  wake = base_src | tmr2_irq | adc_irq | nvm_rdy;
      M_PSAVE,
      M_XSTBY: wake = base_src | (tmr2_irq & tmr2_async);
      M_PDOWN,
      M_STBY:  wake = base_src;
      default: wake = base_src;
    endcase
  end

endmodule

// File: rtl/sleep_seq_fsm.sv
module sleep_seq_fsm
  import sleep_pkg::*;
#(
  parameter int HALT_CYC = 4,
  parameter int CW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slp_en,
  input  logic [2:0]    slp_mode,
  input  logic          slp_exec,
  input  logic          rst_req,
  input  logic          wake,
  input  dom_t          sleep_dom,
  input  logic [CW-1:0] start_len,
  input  logic          bod_ok,
  input  logic          bod_dis_req,
  output mode_e         mode_q,
  output dom_t          dom,
  output logic          core_halt,
  output logic          asleep,
  output logic          resume,
  output logic          rst_vec,
  output logic          bod_off
);

  localparam logic [CW-1:0] HALT_LOAD = CW'(HALT_CYC - 1);

  seq_state_e    st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;
  mode_e         mode_nx;
  logic          held;

  assign held = (st == ST_SLEEP) || (st == ST_START) || (st == ST_HALT);

  always_comb begin
    st_nx   = st;
    cnt_nx  = cnt;
    mode_nx = mode_q;
    unique case (st)
      ST_RUN: begin
        if (slp_exec && slp_en) begin
          st_nx   = ST_SLEEP;
          mode_nx = fold_mode(slp_mode);
        end
      end
      ST_SLEEP: begin
        if (rst_req) begin
          st_nx = ST_RSTV;
        end else if (wake) begin
          if (start_len == '0) begin
            st_nx  = ST_HALT;
            cnt_nx = HALT_LOAD;
          end else begin
            st_nx  = ST_START;
            cnt_nx = start_len - 1'b1;
          end
        end
      end
      ST_START: begin
        if (rst_req) begin
          st_nx = ST_RSTV;
        end else if (cnt == '0) begin
          st_nx  = ST_HALT;
          cnt_nx = HALT_LOAD;
        end else begin
          cnt_nx = cnt - 1'b1;
        end
      end
      ST_HALT: begin
        if (rst_req) begin
          st_nx = ST_RSTV;
        end else if (cnt == '0) begin
          st_nx = ST_RESUME;
        end else begin
          cnt_nx = cnt - 1'b1;
        end
      end
      ST_RESUME: st_nx = ST_RUN;
      ST_RSTV:   st_nx = ST_RUN;
      default:   st_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_RUN;
      cnt    <= '0;
      mode_q <= M_IDLE;
    end else begin
      st     <= st_nx;
      cnt    <= cnt_nx;
      mode_q <= mode_nx;
    end
  end

  always_comb begin
    dom = '1;
    if (st == ST_SLEEP) begin
      dom = sleep_dom;
    end else if (st == ST_START) begin
      dom     = sleep_dom;
      dom.osc = 1'b1;
    end
  end

  assign core_halt = held;
  assign asleep    = (st == ST_SLEEP);
  assign resume    = (st == ST_RESUME);
  assign rst_vec   = (st == ST_RSTV);
  assign bod_off   = (st == ST_SLEEP) && bod_ok && bod_dis_req;

  // R1: a sleep pulse without the enable bit keeps the core running
  a_r1_enable_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && slp_exec && !slp_en) |=> (!asleep && !core_halt));

  // R9: resume only follows a halted cycle outside the sleep wait
  a_r9_resume_after_halt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume) |-> ($past(core_halt) && !$past(asleep) && !rst_vec));

  // R10: reset-vector pulse follows a reset request seen while held
  a_r10_rstv_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rst_vec |-> ($past(rst_req) && $past(core_halt)));

  // R12: the captured mode stays put once the core has left the run state
  a_r12_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (held && slp_exec) |=> $stable(mode_q));

  // R8: all domains on during the halt cycles
  a_r8_halt_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HALT) |-> (&dom));

endmodule

// File: rtl/sleep_sequencer.sv
module sleep_sequencer
  import sleep_pkg::*;
#(
  parameter int T_IDLE   = 0,
  parameter int T_ADCQ   = 0,
  parameter int T_PDOWN  = 16,
  parameter int T_PSAVE  = 16,
  parameter int T_STBY   = 6,
  parameter int T_XSTBY  = 6,
  parameter int HALT_CYC = 4,
  parameter int N_EXT    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slp_en,
  input  logic [2:0]       slp_mode,
  input  logic             slp_exec,
  input  logic             rst_req,
  input  logic [N_EXT-1:0] ext_lvl,
  input  logic [N_EXT-1:0] ext_edge,
  input  logic             pin_chg,
  input  logic             twi_match,
  input  logic             wdt_irq,
  input  logic             tmr2_irq,
  input  logic             tmr2_async,
  input  logic             adc_irq,
  input  logic             nvm_rdy,
  input  logic             misc_irq,
  input  logic             bod_dis_req,
  output logic [5:0]       dom_en,
  output logic             core_halt,
  output logic             asleep,
  output logic             resume,
  output logic             rst_vec,
  output logic             bod_off
);

  localparam int T_MAX_A = (T_PDOWN > T_PSAVE) ? T_PDOWN : T_PSAVE;
  localparam int T_MAX_B = (T_STBY > T_XSTBY) ? T_STBY : T_XSTBY;
  localparam int T_MAX_C = (T_IDLE > T_ADCQ) ? T_IDLE : T_ADCQ;
  localparam int T_MAX_D = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
  localparam int T_MAX_E = (T_MAX_D > T_MAX_C) ? T_MAX_D : T_MAX_C;
  localparam int CNT_TOP = (T_MAX_E > HALT_CYC) ? T_MAX_E : HALT_CYC;
  localparam int CW      = $clog2(CNT_TOP + 1);

  mode_e         mode_q;
  dom_t          sleep_dom;
  dom_t          dom;
  logic [CW-1:0] start_len;
  logic          bod_ok;
  logic          wake;

  sleep_mode_map #(
    .T_IDLE (T_IDLE),
    .T_ADCQ (T_ADCQ),
    .T_PDOWN(T_PDOWN),
    .T_PSAVE(T_PSAVE),
    .T_STBY (T_STBY),
    .T_XSTBY(T_XSTBY),
    .CW     (CW)
  ) i_map (
    .mode     (mode_q),
    .sleep_dom(sleep_dom),
    .start_len(start_len),
    .bod_ok   (bod_ok)
  );

  sleep_wake_qual #(.N_EXT(N_EXT)) i_qual (
    .mode      (mode_q),
    .ext_lvl   (ext_lvl),
    .ext_edge  (ext_edge),
    .pin_chg   (pin_chg),
    .twi_match (twi_match),
    .wdt_irq   (wdt_irq),
    .tmr2_irq  (tmr2_irq),
    .tmr2_async(tmr2_async),
    .adc_irq   (adc_irq),
    .nvm_rdy   (nvm_rdy),
    .misc_irq  (misc_irq),
    .wake      (wake)
  );

  sleep_seq_fsm #(.HALT_CYC(HALT_CYC), .CW(CW)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .slp_en     (slp_en),
    .slp_mode   (slp_mode),
    .slp_exec   (slp_exec),
    .rst_req    (rst_req),
    .wake       (wake),
    .sleep_dom  (sleep_dom),
    .start_len  (start_len),
    .bod_ok     (bod_ok),
    .bod_dis_req(bod_dis_req),
    .mode_q     (mode_q),
    .dom        (dom),
    .core_halt  (core_halt),
    .asleep     (asleep),
    .resume     (resume),
    .rst_vec    (rst_vec),
    .bod_off    (bod_off)
  );

  assign dom_en = dom;

  // R3: the CPU domain is stopped whenever the core sleeps
  a_r3_cpu_off_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !dom_en[5]);

  // R11: brown-out disable only while asleep in a mode that stops the I/O domain
  a_r11_bod_deep_only: assert property (@(posedge clk) disable iff (!rst_n)
    bod_off |-> (asleep && !dom_en[3] && !dom_en[2]));

  // R9: resume and reset-vector never together, and the core runs then
  a_r9_exit_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (resume || rst_vec) |-> ($onehot0({resume, rst_vec}) && !core_halt && (&dom_en)));

endmodule

// File: tb/test_sleep_sequencer.sv
module test_sleep_sequencer;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slp_en = 1'b0;
  logic [2:0] slp_mode = 3'b000;
  logic       slp_exec = 1'b0;
  logic       rst_req = 1'b0;
  logic [1:0] ext_lvl = 2'b00;
  logic [1:0] ext_edge = 2'b00;
  logic       pin_chg = 1'b0, twi_match = 1'b0, wdt_irq = 1'b0;
  logic       tmr2_irq = 1'b0, tmr2_async = 1'b0, adc_irq = 1'b0;
  logic       nvm_rdy = 1'b0, misc_irq = 1'b0, bod_dis_req = 1'b0;
  logic [5:0] dom_en;
  logic       core_halt, asleep, resume, rst_vec, bod_off;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_sequencer i_sleep_sequencer (
    .clk(clk), .rst_n(rst_n), .slp_en(slp_en), .slp_mode(slp_mode),
    .slp_exec(slp_exec), .rst_req(rst_req), .ext_lvl(ext_lvl),
    .ext_edge(ext_edge), .pin_chg(pin_chg), .twi_match(twi_match),
    .wdt_irq(wdt_irq), .tmr2_irq(tmr2_irq), .tmr2_async(tmr2_async),
    .adc_irq(adc_irq), .nvm_rdy(nvm_rdy), .misc_irq(misc_irq),
    .bod_dis_req(bod_dis_req), .dom_en(dom_en), .core_halt(core_halt),
    .asleep(asleep), .resume(resume), .rst_vec(rst_vec), .bod_off(bod_off)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Expected values written from R3 and R7
  function automatic logic [5:0] exp_dom(input logic [2:0] m);
    case (m)
      3'b001:  return 6'b000111;
      3'b010:  return 6'b000000;
      3'b011:  return 6'b000010;
      3'b110:  return 6'b000001;
      3'b111:  return 6'b000011;
      default: return 6'b001111;
    endcase
  endfunction

  function automatic int exp_start(input logic [2:0] m);
    case (m)
      3'b010, 3'b011: return 16;
      3'b110, 3'b111: return 6;
      default:        return 0;
    endcase
  endfunction

  function automatic bit deep(input logic [2:0] m);
    return (m == 3'b010) || (m == 3'b011) || (m == 3'b110) || (m == 3'b111);
  endfunction

  task automatic clear_src();
    ext_lvl = 0; ext_edge = 0; pin_chg = 0; twi_match = 0; wdt_irq = 0;
    tmr2_irq = 0; adc_irq = 0; nvm_rdy = 0; misc_irq = 0;
  endtask

  task automatic enter(input logic [2:0] m);
    slp_en = 1'b1; slp_mode = m; slp_exec = 1'b1;
    tick();
    slp_exec = 1'b0; slp_en = 1'b0;
  endtask

  // Source must already be driven; measures edges to resume (R7, R8, R9).
  task automatic measure_exit(input logic [2:0] m, input string tag);
    int n = 0;
    int exp_n = exp_start(m) + 5;
    bit seen = 1'b0;
    for (int k = 0; k < 40; k++) begin
      tick();
      n++;
      if (k == 0) clear_src();
      if (resume) begin seen = 1'b1; break; end
      if (!core_halt) begin
        check(1'b0, {tag, " R8 halt held"}, 0, 1);
        break;
      end
      if (n <= exp_start(m))
        check(dom_en == (exp_dom(m) | 6'b000001), {tag, " R8 startup domains"}, dom_en, exp_dom(m) | 1);
      else
        check(dom_en == 6'b111111, {tag, " R8 halt domains"}, dom_en, 63);
    end
    check(seen && n == exp_n, {tag, " R7 exit length"}, n, exp_n);
    check(!core_halt && !rst_vec, {tag, " R9 resume cycle"}, {core_halt, rst_vec}, 0);
    tick();
    check(!resume && !core_halt && dom_en == 6'b111111, {tag, " R9 single pulse"}, resume, 0);
  endtask

  task automatic t_reset_state();
    check(dom_en == 6'b111111, "R13 domains", dom_en, 63);
    check({core_halt, asleep, resume, rst_vec, bod_off} == 5'b0, "R13 flags",
          {core_halt, asleep, resume, rst_vec, bod_off}, 0);
  endtask

  task automatic t_noop();
    slp_en = 1'b0; slp_mode = 3'b010; slp_exec = 1'b1;
    tick();
    slp_exec = 1'b0;
    check(!asleep && !core_halt && dom_en == 6'b111111, "R1 exec without enable", asleep, 0);
    rst_req = 1'b1;
    tick();
    rst_req = 1'b0;
    check(!rst_vec, "R10 reset request while running", rst_vec, 0);
  endtask

  task automatic t_mode(input logic [2:0] m, input string tag);
    bod_dis_req = 1'b1;
    enter(m);
    check(asleep && core_halt, {tag, " R1 entered"}, asleep, 1);
    check(dom_en == exp_dom(m), {tag, " R3 domains"}, dom_en, exp_dom(m));
    check(bod_off == deep(m), {tag, " R11 bod"}, bod_off, deep(m));
    bod_dis_req = 1'b0;
    wdt_irq = 1'b1;
    measure_exit(m, tag);
  endtask

  task automatic t_edge_vs_level();
    enter(3'b010);
    ext_edge = 2'b11; misc_irq = 1'b1; adc_irq = 1'b1;
    tick(); tick();
    check(asleep, "R5 edge ignored in power-down", asleep, 1);
    check(asleep, "R4 misc and adc ignored in power-down", asleep, 1);
    clear_src();
    ext_lvl = 2'b10;
    measure_exit(3'b010, "pdown level");
    enter(3'b000);
    ext_edge = 2'b01;
    measure_exit(3'b000, "idle edge R4");
    enter(3'b001);
    nvm_rdy = 1'b1;
    measure_exit(3'b001, "adcq nvm R4");
  endtask

  task automatic t_timer2();
    enter(3'b011);
    tmr2_async = 1'b0; tmr2_irq = 1'b1;
    tick(); tick();
    check(asleep, "R6 sync timer ignored in power-save", asleep, 1);
    clear_src();
    tmr2_async = 1'b1; tmr2_irq = 1'b1;
    measure_exit(3'b011, "psave async R6");
    enter(3'b110);
    tmr2_irq = 1'b1;
    tick(); tick();
    check(asleep, "R6 timer ignored in standby", asleep, 1);
    clear_src();
    pin_chg = 1'b1;
    measure_exit(3'b110, "stby pin R4");
    enter(3'b111);
    tmr2_irq = 1'b1;
    measure_exit(3'b111, "xstby async R6");
    tmr2_async = 1'b0;
  endtask

  task automatic t_reset_in_sleep();
    enter(3'b010);
    twi_match = 1'b1;
    tick();
    clear_src();
    tick(); tick();
    rst_req = 1'b1;
    tick();
    rst_req = 1'b0;
    check(rst_vec && !resume, "R10 reset vector during startup", rst_vec, 1);
    check(dom_en == 6'b111111 && !core_halt, "R10 domains on", dom_en, 63);
    tick();
    check(!rst_vec && !resume && !core_halt, "R10 single pulse", rst_vec, 0);
    enter(3'b011);
    rst_req = 1'b1; wdt_irq = 1'b1;
    tick();
    rst_req = 1'b0; clear_src();
    check(rst_vec && !resume, "R10 priority over wake", rst_vec, 1);
    tick();
  endtask

  task automatic t_exec_while_asleep();
    enter(3'b010);
    slp_en = 1'b1; slp_mode = 3'b000; slp_exec = 1'b1;
    tick();
    slp_exec = 1'b0; slp_en = 1'b0;
    check(asleep && dom_en == 6'b000000, "R12 second exec ignored", dom_en, 0);
    misc_irq = 1'b1;
    tick();
    clear_src();
    check(asleep, "R12 mode kept (idle-only source ignored)", asleep, 1);
    wdt_irq = 1'b1;
    measure_exit(3'b010, "pdown after exec R12");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_noop();
    t_mode(3'b000, "idle R2");
    t_mode(3'b001, "adcq");
    t_mode(3'b010, "pdown");
    t_mode(3'b011, "psave");
    t_mode(3'b110, "stby");
    t_mode(3'b111, "xstby");
    t_mode(3'b100, "reserved100 R2");
    t_mode(3'b101, "reserved101 R2");
    t_edge_vs_level();
    t_timer2();
    t_reset_in_sleep();
    t_exec_while_asleep();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule